// File: doc/BRIEF.md
# Banked Two-Read One-Write Register File

This block stores 64-bit architectural registers as two 32-bit halves. The halves go into four banks. Which bank a half lands in depends on whether it is the upper or lower word, and on whether the register number is even or odd. Each bank is a small flop array with two read ports and one write port per clock, and it has a write enable for every byte.

A caller presents a set of read requests and write requests each cycle. Each read request carries a register number and a two-bit half mask. A read that asks for both halves occupies two banks, one per half, within the same parity group. Each write request carries a register number, an 8-bit byte mask and 64 bits of data. A write claims a bank only for a half where at least one of its byte enables is set.

When a cycle asks more of a bank than its ports allow, the lowest-numbered requests are served. The rest are dropped, and the bank's conflict flag is raised. Read data is combinational. It comes from the stored array, with same-cycle write data forwarded byte by byte. Writes commit at the rising clock edge.

Top module: `banked_regfile`

## Requirements
- R1: Register r maps to bank index {half, r[0]}: bank 0 holds even low halves, bank 1 odd low halves, bank 2 even high halves, bank 3 odd high halves. The low half is data bits 31:0 and byte enables 3:0; the high half is bits 63:32 and byte enables 7:4. Within a bank the entry is r shifted right by one.
- R2: A granted read returns the stored contents of its register combinationally in the same cycle. A write becomes visible to reads from the cycle after its rising clock edge.
- R3: A granted write changes only the bytes whose enable bit is set. All other bytes of that register keep their values.
- R4: When a granted write and a granted read address the same register in one cycle, each byte the write enables is forwarded from the write data to the read output. The other bytes come from storage.
- R5: At most two read half-requests are served per bank per cycle, by ascending read-port number. Any further request to that bank returns zero for that half and sets bank_conflict for that bank. Requests spread over different banks never conflict.
- R6: At most one write is served per bank per cycle, and it is the lowest-numbered write port that touches the bank. A later write to the same bank is not stored and not forwarded, and it sets bank_conflict for that bank.
- R7: A read port with rd_half bit 0 clear (low) or bit 1 clear (high) does not occupy that half's bank, and it returns zero in that half.
- R8: A synchronous active-high reset clears every register to zero at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| rd_en | input | RD_PORTS | Read request valid per port |
| rd_addr | input | RD_PORTS x REG_AW | Register number per read port |
| rd_half | input | RD_PORTS x 2 | Half mask per read port: bit 0 low, bit 1 high |
| rd_data | output | RD_PORTS x 64 | Read data per port, zero in halves not served |
| wr_en | input | WR_PORTS | Write request valid per port |
| wr_addr | input | WR_PORTS x REG_AW | Register number per write port |
| wr_be | input | WR_PORTS x 8 | Byte enables per write port |
| wr_data | input | WR_PORTS x 64 | Write data per port |
| bank_conflict | output | 4 | Per bank: more reads or writes requested than ports |

## Verification
The bench concentrates on bank overload. It sends three or four read halves to a single bank, including cases where one port asks for both halves, and it sends two writes to one bank with different byte masks. If the order were wrong, the design would zero the wrong port or keep the wrong write. Forwarding is checked with partial byte masks, and again when the write that would forward is itself dropped. A design that forwarded whole words, or forwarded from a losing write, would return wrong bytes. A long run with random stimulus over a handful of registers hits collisions between the same entry and the same bank often, and a mid-run reset confirms that no stale data survives.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int HALF_W     = 32;
  localparam int HALF_BYTES = HALF_W / 8;
  localparam int NUM_BANKS  = 4;
  localparam int BANK_RD    = 2;
  localparam int BANK_WR    = 1;

  typedef logic [HALF_W-1:0]     half_t;
  typedef logic [HALF_BYTES-1:0] hbe_t;

  function automatic half_t byte_mask(input hbe_t be);
    half_t m;
    for (int j = 0; j < HALF_BYTES; j++) m[j*8 +: 8] = {8{be[j]}};
    return m;
  endfunction
endpackage

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int EW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [EW-1:0]           waddr,
  input  hbe_t                    wbe,
  input  half_t                   wdata,
  input  logic [BANK_RD-1:0][EW-1:0] ra,
  output half_t [BANK_RD-1:0]     rd
);
  half_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      for (int j = 0; j < HALF_BYTES; j++)
        if (wbe[j]) mem[waddr][j*8 +: 8] <= wdata[j*8 +: 8];
    end
  end

  for (genvar k = 0; k < BANK_RD; k++) begin : g_rd
    half_t stored;
    logic  hit;
    assign stored = mem[ra[k]];
    assign hit    = we && (waddr == ra[k]);
    always_comb begin
      for (int j = 0; j < HALF_BYTES; j++)
        rd[k][j*8 +: 8] = (hit && wbe[j]) ? wdata[j*8 +: 8] : stored[j*8 +: 8];
    end
  end

  assert_enabled_bytes_R3: assert property (@(posedge clk) disable iff (rst)
    we |=> ((mem[$past(waddr)] & byte_mask($past(wbe))) ==
            ($past(wdata) & byte_mask($past(wbe)))));

  assert_other_bytes_kept_R3: assert property (@(posedge clk) disable iff (rst)
    we |=> ((mem[$past(waddr)] & ~byte_mask($past(wbe))) ==
            ($past(mem[waddr]) & ~byte_mask($past(wbe)))));

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (mem[ra[0]] == '0));
endmodule

// File: rtl/rf_arbiter.sv
module rf_arbiter #(
  parameter int N     = 4,
  parameter int LIMIT = 2,
  localparam int SW = (LIMIT > 1) ? $clog2(LIMIT) : 1,
  localparam int CW = $clog2(N + 2)
) (
  input  logic [N-1:0]          req,
  output logic [N-1:0]          gnt,
  output logic [N-1:0][SW-1:0]  slot,
  output logic                  overflow
);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int p = 0; p < N; p++) begin
      gnt[p]  = 1'b0;
      slot[p] = '0;
      if (req[p]) begin
        if (cnt < CW'(LIMIT)) begin
          gnt[p]  = 1'b1;
          slot[p] = SW'(cnt);
        end
        cnt = cnt + 1'b1;
      end
    end
    overflow = (cnt > CW'(LIMIT));
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int BANK_DEPTH = 128,
  parameter int RD_PORTS   = 4,
  parameter int WR_PORTS   = 2,
  localparam int EW     = $clog2(BANK_DEPTH),
  localparam int REG_AW = EW + 1,
  localparam int RSW    = (BANK_RD > 1) ? $clog2(BANK_RD) : 1,
  localparam int WSW    = 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [RD_PORTS-1:0]               rd_en,
  input  logic [RD_PORTS-1:0][REG_AW-1:0]   rd_addr,
  input  logic [RD_PORTS-1:0][1:0]          rd_half,
  output logic [RD_PORTS-1:0][63:0]         rd_data,
  input  logic [WR_PORTS-1:0]               wr_en,
  input  logic [WR_PORTS-1:0][REG_AW-1:0]   wr_addr,
  input  logic [WR_PORTS-1:0][7:0]          wr_be,
  input  logic [WR_PORTS-1:0][63:0]         wr_data,
  output logic [NUM_BANKS-1:0]              bank_conflict
);
  logic [RD_PORTS-1:0]           rd_req  [NUM_BANKS];
  logic [RD_PORTS-1:0]           rd_gnt  [NUM_BANKS];
  logic [RD_PORTS-1:0][RSW-1:0]  rd_slot [NUM_BANKS];
  logic [WR_PORTS-1:0]           wr_req  [NUM_BANKS];
  logic [WR_PORTS-1:0]           wr_gnt  [NUM_BANKS];
  logic [WR_PORTS-1:0][WSW-1:0]  wr_slot [NUM_BANKS];
  half_t [BANK_RD-1:0]           bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int PAR = b % 2;
    localparam int HI  = b / 2;
    logic rd_ovf, wr_ovf, b_we;
    logic [EW-1:0] b_waddr;
    hbe_t  b_wbe;
    half_t b_wdata;
    logic [BANK_RD-1:0][EW-1:0] b_ra;

    always_comb begin
      for (int p = 0; p < RD_PORTS; p++)
        rd_req[b][p] = rd_en[p] && (rd_addr[p][0] == 1'(PAR)) && rd_half[p][HI];
      for (int w = 0; w < WR_PORTS; w++)
        wr_req[b][w] = wr_en[w] && (wr_addr[w][0] == 1'(PAR))
                       && (|wr_be[w][HI*HALF_BYTES +: HALF_BYTES]);
    end

    rf_arbiter #(.N(RD_PORTS), .LIMIT(BANK_RD)) u_rd_arb (
      .req(rd_req[b]), .gnt(rd_gnt[b]), .slot(rd_slot[b]), .overflow(rd_ovf));

    rf_arbiter #(.N(WR_PORTS), .LIMIT(BANK_WR)) u_wr_arb (
      .req(wr_req[b]), .gnt(wr_gnt[b]), .slot(wr_slot[b]), .overflow(wr_ovf));

    // one-hot grants select the bank inputs with an AND-OR, no priority mux
    always_comb begin
      b_ra = '0;
      for (int k = 0; k < BANK_RD; k++)
        for (int p = 0; p < RD_PORTS; p++)
          if (rd_gnt[b][p] && (rd_slot[b][p] == RSW'(k)))
            b_ra[k] = b_ra[k] | rd_addr[p][REG_AW-1:1];
      b_we = 1'b0; b_waddr = '0; b_wbe = '0; b_wdata = '0;
      for (int w = 0; w < WR_PORTS; w++)
        if (wr_gnt[b][w] && (wr_slot[b][w] == '0)) begin
          b_we    = 1'b1;
          b_waddr = b_waddr | wr_addr[w][REG_AW-1:1];
          b_wbe   = b_wbe   | wr_be[w][HI*HALF_BYTES +: HALF_BYTES];
          b_wdata = b_wdata | wr_data[w][HI*HALF_W +: HALF_W];
        end
    end

    rf_bank #(.DEPTH(BANK_DEPTH)) u_bank (
      .clk(clk), .rst(rst), .we(b_we), .waddr(b_waddr), .wbe(b_wbe),
      .wdata(b_wdata), .ra(b_ra), .rd(bank_rd[b]));

    assign bank_conflict[b] = rd_ovf | wr_ovf;

    assert_read_cap_R5: assert property (@(posedge clk) disable iff (rst)
      $countones(rd_gnt[b]) <= BANK_RD);
    assert_read_grant_requested_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_gnt[b] & ~rd_req[b]) == '0);
    assert_write_single_R6: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_gnt[b]));
    assert_conflict_flag_R6: assert property (@(posedge clk) disable iff (rst)
      bank_conflict[b] == (($countones(rd_req[b]) > BANK_RD) ||
                           ($countones(wr_req[b]) > BANK_WR)));
  end

  always_comb begin
    for (int p = 0; p < RD_PORTS; p++)
      for (int h = 0; h < 2; h++) begin
        rd_data[p][h*HALF_W +: HALF_W] = '0;
        for (int b = 0; b < NUM_BANKS; b++)
          if ((b / 2 == h) && rd_gnt[b][p])
            rd_data[p][h*HALF_W +: HALF_W] = bank_rd[b][rd_slot[b][p]];
      end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd_chk
    assert_masked_half_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (!rd_en[p] || !rd_half[p][0]) |-> (rd_data[p][31:0] == '0));
  end
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 128;
  localparam int NRD    = 4;
  localparam int NWR    = 2;
  localparam int AW     = $clog2(DEPTH) + 1;
  localparam int NREGS  = 2 * DEPTH;

  logic clk = 0;
  logic rst;
  logic [NRD-1:0]         rd_en;
  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][1:0]    rd_half;
  logic [NRD-1:0][63:0]   rd_data;
  logic [NWR-1:0]         wr_en;
  logic [NWR-1:0][AW-1:0] wr_addr;
  logic [NWR-1:0][7:0]    wr_be;
  logic [NWR-1:0][63:0]   wr_data;
  logic [3:0]             bank_conflict;

  int errors = 0;
  int checks = 0;
  logic [63:0] model [NREGS];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  banked_regfile #(.BANK_DEPTH(DEPTH), .RD_PORTS(NRD), .WR_PORTS(NWR)) u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_half(rd_half),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .bank_conflict(bank_conflict));

  task automatic idle();
    rd_en = '0; rd_addr = '0; rd_half = '0;
    wr_en = '0; wr_addr = '0; wr_be = '0; wr_data = '0;
  endtask

  task automatic set_rd(int p, int a, logic [1:0] h);
    rd_en[p] = 1'b1; rd_addr[p] = AW'(a); rd_half[p] = h;
  endtask

  task automatic set_wr(int w, int a, logic [7:0] be, logic [63:0] d);
    wr_en[w] = 1'b1; wr_addr[w] = AW'(a); wr_be[w] = be; wr_data[w] = d;
  endtask

  // behavioural reference: winner per bank, counted reads, byte merge
  task automatic step(string tag);
    int winner [4];
    int wcnt [4];
    int rcnt [4];
    logic [63:0] exp_d [NRD];
    logic [3:0] exp_c;
    for (int b = 0; b < 4; b++) begin winner[b] = -1; wcnt[b] = 0; rcnt[b] = 0; end
    for (int w = 0; w < NWR; w++)
      for (int h = 0; h < 2; h++)
        if (wr_en[w] && (wr_be[w][h*4 +: 4] != 0)) begin
          int b = h*2 + int'(wr_addr[w][0]);
          wcnt[b]++;
          if (winner[b] < 0) winner[b] = w;
        end
    for (int p = 0; p < NRD; p++) begin
      exp_d[p] = '0;
      for (int h = 0; h < 2; h++)
        if (rd_en[p] && rd_half[p][h]) begin
          int b = h*2 + int'(rd_addr[p][0]);
          rcnt[b]++;
          if (rcnt[b] <= 2) begin
            for (int j = h*4; j < h*4 + 4; j++) begin
              logic [7:0] v;
              v = model[rd_addr[p]][j*8 +: 8];
              if (winner[b] >= 0 && wr_addr[winner[b]] == rd_addr[p] && wr_be[winner[b]][j])
                v = wr_data[winner[b]][j*8 +: 8];
              exp_d[p][j*8 +: 8] = v;
            end
          end
        end
    end
    for (int b = 0; b < 4; b++) exp_c[b] = (rcnt[b] > 2) || (wcnt[b] > 1);
    #(CLK_P/4);
    if (!rst) begin
      for (int p = 0; p < NRD; p++) begin
        checks++;
        if (rd_data[p] !== exp_d[p]) begin
          errors++;
          $display("FAIL %s port %0d: actual=%h expected=%h", tag, p, rd_data[p], exp_d[p]);
        end
      end
      checks++;
      if (bank_conflict !== exp_c) begin
        errors++;
        $display("FAIL %s conflict: actual=%b expected=%b", tag, bank_conflict, exp_c);
      end
    end
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < NREGS; i++) model[i] = '0;
    end else begin
      for (int b = 0; b < 4; b++)
        if (winner[b] >= 0)
          for (int j = (b/2)*4; j < (b/2)*4 + 4; j++)
            if (wr_be[winner[b]][j])
              model[wr_addr[winner[b]]][j*8 +: 8] = wr_data[winner[b]][j*8 +: 8];
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREGS; i++) model[i] = 64'hDEAD_BEEF_DEAD_BEEF;
    idle(); rst = 1;
    @(negedge clk);
    step("R8"); step("R8");
    rst = 0;
    // R8: everything reads zero after reset
    set_rd(0, 0, 2'b11); set_rd(1, 1, 2'b11); set_rd(2, 2, 2'b01); set_rd(3, 3, 2'b10);
    step("R8");
    idle();
    // R2 / R4: full write to reg 5 with a same-cycle full read
    set_wr(0, 5, 8'hFF, 64'h1122_3344_5566_7788); set_rd(0, 5, 2'b11);
    step("R4");
    idle(); set_rd(0, 5, 2'b11); step("R2");
    // R3 / R4: partial byte write with forwarding of only enabled bytes
    idle(); set_wr(0, 5, 8'b1010_0101, 64'hAAAA_BBBB_CCCC_DDDD); set_rd(1, 5, 2'b11);
    step("R4");
    idle(); set_rd(2, 5, 2'b11); step("R3");
    // R1: both halves of one even register written by two ports, no conflict
    idle(); set_wr(0, 6, 8'h0F, 64'h0000_0000_CAFE_0006); set_wr(1, 6, 8'hF0, 64'hF00D_0006_0000_0000);
    step("R1");
    idle(); set_rd(0, 6, 2'b11); set_rd(1, 5, 2'b11); set_rd(2, 6, 2'b01); set_rd(3, 5, 2'b10);
    step("R1");
    // R5: three full even reads overload banks 0 and 2; port 2 zeroed
    idle(); set_rd(0, 6, 2'b11); set_rd(1, 6, 2'b11); set_rd(2, 6, 2'b11); set_rd(3, 5, 2'b11);
    step("R5");
    // R5: only low halves overloaded, high half of port 2 still served
    idle(); set_rd(0, 6, 2'b01); set_rd(1, 6, 2'b01); set_rd(2, 6, 2'b11);
    step("R5");
    // R6: two writes into one bank, lower port wins, loser neither stored nor forwarded
    idle(); set_wr(0, 8, 8'h0F, 64'h0000_0000_1111_1111); set_wr(1, 8, 8'h03, 64'h0000_0000_2222_2222);
    set_rd(0, 8, 2'b01);
    step("R6");
    idle(); set_wr(0, 10, 8'h01, 64'h77); set_wr(1, 8, 8'h0C, 64'h0000_0000_3333_3333);
    set_rd(0, 8, 2'b11);
    step("R6");
    idle(); set_rd(0, 8, 2'b11); set_rd(1, 10, 2'b11); step("R6");
    // R7: half masks leave the other half zero and unused
    idle(); set_rd(0, 5, 2'b10); set_rd(1, 5, 2'b01); set_rd(2, 5, 2'b10); set_rd(3, 5, 2'b01);
    rd_en[3] = 1'b0;
    step("R7");
    // random traffic over a few registers for many collisions
    for (int c = 0; c < 3000; c++) begin
      idle();
      for (int p = 0; p < NRD; p++)
        if ($urandom_range(0, 3) != 0) set_rd(p, $urandom_range(0, 7), 2'($urandom_range(1, 3)));
      for (int w = 0; w < NWR; w++)
        if ($urandom_range(0, 1) != 0)
          set_wr(w, $urandom_range(0, 7), 8'($urandom), {$urandom, $urandom});
      step("R2");
    end
    // R8: mid-run reset wipes data
    idle(); rst = 1; step("R8"); rst = 0;
    for (int r = 0; r < 8; r += 4) begin
      idle();
      for (int p = 0; p < NRD; p++) set_rd(p, r + p, 2'b11);
      step("R8");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule